// File: doc/BRIEF.md
# Locking Pseudo-LRU Victim Selector

This block chooses which way of an eight-way set-associative cache is refilled next. For each set it holds a binary tree of pseudo-LRU bits: seven bits for eight ways. Every hit or refill to a way moves the bits on that way's path so that they point away from it. The cache controller presents a set index. The block then returns, in the same cycle, the victim way for that set, worked out from the stored tree and the current lock settings.

Software can lock single ways through a per-way mask, or lock the whole cache with one enable. A locked way is never returned as a victim. Where the tree points into a subtree whose ways are all locked, the selector turns into the sibling subtree. When no way is free, it raises a no-victim flag so that the controller suppresses allocation. Accesses to locked ways still move the tree. A global invalidate clears every set's tree.

Top module: `plru_way_sel`

## Requirements
- R1: After a synchronous active-low reset every tree bit of every set is 0, so with no locks the victim of every set is way 0.
- R2: The tree of a set is a heap of NUM_WAYS-1 bits, with node n (1-based, root n=1, children 2n and 2n+1) stored at bit n-1. At each node a 0 points to the lower-numbered half of the ways and a 1 to the upper half. With no locks, victim_way is the leaf reached by following the bits from the root. It is combinational from the stored state of set acc_set.
- R3: A cycle with acc_valid=1 sets every node on the path to acc_way in set acc_set so that it points away from acc_way. The update is seen from the next cycle on. Nodes off the path, and all other sets, keep their values.
- R4: victim_way never names a way whose lock_mask bit is 1 while no_victim is 0.
- R5: When the node bit points to a subtree whose ways are all locked and the sibling subtree holds a free way, the selector descends into the sibling. Nodes without that conflict are followed as stored.
- R6: When every way is locked, no_victim is 1 and victim_way is 0. Otherwise no_victim is 0.
- R7: lock_all=1 acts as if every lock_mask bit were 1, whatever the mask holds.
- R8: An access to a locked way, or an access made while lock_all=1, updates the tree exactly as an access to a free way would.
- R9: inval_all=1 clears the tree of every set at the next edge. It takes precedence over an access in the same cycle.
- R10: Right after an access to way w of set s, with at least two ways free, the victim of set s is not w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inval_all | input | 1 | Clear all tree state |
| acc_valid | input | 1 | Hit or refill strobe for acc_set/acc_way |
| acc_set | input | SET_W | Set index for both lookup and update |
| acc_way | input | WAY_W | Way touched by the access |
| lock_mask | input | NUM_WAYS | Per-way lock, bit i locks way i |
| lock_all | input | 1 | Lock the whole cache |
| victim_way | output | WAY_W | Way to replace in set acc_set |
| no_victim | output | 1 | No way may be allocated |

## Verification
A reference tree model in the bench is driven by long pseudo-random access streams in each set of a four-set configuration. The victim is checked before every access, which separates correct path updates from updates to the wrong nodes or sets. For several tree states the bench then sweeps all 256 lock masks, which separates a correct sibling override and no-victim detection from a selector that ignores locks or only looks at the leaves. Separate runs lock the whole cache, access locked ways, check that the victim moves away from the last way accessed, and invalidate the cache during an access, each showing whether the override or the update path has priority.

// File: rtl/plru_pkg.sv
// Package plru_pkg
// Helper functions for heap-indexed pseudo-LRU trees. The root is node 1;
// node n has children 2n and 2n+1; the leaf of way w is node NUM_WAYS+w.
// Assumes the number of ways is a power of two.
package plru_pkg;

    // Heap index of the tree node at depth lvl (root at 0) on the path to a way.
    function automatic int path_node(input int way, input int lvl, input int levels, input int ways);
        return (ways + way) >> (levels - lvl);
    endfunction

    // Branch taken at depth lvl on the path to a way: 0 lower half, 1 upper half.
    function automatic logic path_dir(input int way, input int lvl, input int levels, input int ways);
        int leaf;
        leaf = ways + way;
        return logic'((leaf >> (levels - 1 - lvl)) & 1);
    endfunction

endpackage

// File: rtl/plru_tree_store.sv
// Module plru_tree_store
// Holds one pseudo-LRU tree word per set. There is one combinational read
// port and one write port. A clear over all sets has priority over the write.
// Assumes a synchronous active-low reset that also clears every set.
module plru_tree_store #(
    parameter int NUM_SETS = 64,
    parameter int NODES    = 7,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [NODES-1:0] wr_bits,
    input  logic [SET_W-1:0] rd_set,
    output logic [NODES-1:0] rd_bits
);

    logic [NODES-1:0] tree_q [NUM_SETS];

    // Tree storage: clear on reset or invalidate, otherwise take the write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (wr_en) begin
            tree_q[wr_set] <= wr_bits;
        end
    end

    // Read port: the current tree of the addressed set.
    always_comb begin
        rd_bits = tree_q[rd_set];
    end

endmodule

// File: rtl/plru_path_update.sv
// Module plru_path_update
// Works out the new tree word after an access to one way. Every node on the
// path from the root to that way is made to point away from it. The other
// nodes pass through unchanged. Purely combinational.
module plru_path_update
    import plru_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int LEVELS  = $clog2(NUM_WAYS),
    localparam int NODES   = NUM_WAYS - 1
) (
    input  logic [NODES-1:0]  cur_bits,
    input  logic [LEVELS-1:0] way,
    output logic [NODES-1:0]  new_bits
);

    // Path rewrite: flip each node on the path to the far side of the way.
    always_comb begin
        new_bits = cur_bits;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            new_bits[path_node(int'(way), lvl, LEVELS, NUM_WAYS) - 1] =
                ~path_dir(int'(way), lvl, LEVELS, NUM_WAYS);
        end
    end

endmodule

// File: rtl/plru_victim_pick.sv
// Module plru_victim_pick
// Walks the tree from the root to a leaf. At each node it follows the stored
// bit unless that side holds no free way, and then takes the sibling. A
// reduction tree of free flags, one flag per heap node, makes that choice.
// When no way is free it reports none and returns way 0.
module plru_victim_pick #(
    parameter int NUM_WAYS = 8,
    localparam int LEVELS  = $clog2(NUM_WAYS),
    localparam int NODES   = NUM_WAYS - 1
) (
    input  logic [NODES-1:0]    tree_bits,
    input  logic [NUM_WAYS-1:0] locked,
    output logic [LEVELS-1:0]   victim,
    output logic                none_free
);

    logic [2*NUM_WAYS-1:1] node_free;

    // Leaf flags: a way is free when it is not locked.
    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_leaf
            assign node_free[NUM_WAYS + g] = ~locked[g];
        end
        // Inner flags: a subtree is free when either child subtree is.
        for (g = 1; g < NUM_WAYS; g++) begin : g_inner
            assign node_free[g] = node_free[2*g] | node_free[2*g + 1];
        end
    endgenerate

    // Descent: follow the stored bits, steering away from fully locked halves.
    always_comb begin
        int   n;
        logic go_up;
        n = 1;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            go_up = tree_bits[n - 1];
            if (go_up && !node_free[2*n + 1]) begin
                go_up = 1'b0;
            end else if (!go_up && !node_free[2*n]) begin
                go_up = 1'b1;
            end
            n = 2*n + int'(go_up);
        end
        none_free = ~node_free[1];
        victim    = none_free ? '0 : LEVELS'(n - NUM_WAYS);
    end

endmodule

// File: rtl/plru_way_sel.sv
// Module plru_way_sel
// Victim way selector for a set-associative cache. It keeps pseudo-LRU tree
// state for each set and honours per-way and whole-cache locks. The victim
// is combinational from the stored state of acc_set. Tree updates are
// registered on acc_valid. Assumes NUM_WAYS is a power of two of at least 2.
module plru_way_sel #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 64,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int NODES   = NUM_WAYS - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inval_all,
    input  logic                acc_valid,
    input  logic [SET_W-1:0]    acc_set,
    input  logic [WAY_W-1:0]    acc_way,
    input  logic [NUM_WAYS-1:0] lock_mask,
    input  logic                lock_all,
    output logic [WAY_W-1:0]    victim_way,
    output logic                no_victim
);

    logic [NUM_WAYS-1:0] eff_lock;
    logic [NODES-1:0]    cur_bits;
    logic [NODES-1:0]    next_bits;

    // Lock merge: the whole-cache lock overrides the per-way mask.
    always_comb begin
        eff_lock = lock_all ? {NUM_WAYS{1'b1}} : lock_mask;
    end

    plru_tree_store #(
        .NUM_SETS (NUM_SETS),
        .NODES    (NODES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (inval_all),
        .wr_en     (acc_valid),
        .wr_set    (acc_set),
        .wr_bits   (next_bits),
        .rd_set    (acc_set),
        .rd_bits   (cur_bits)
    );

    plru_path_update #(
        .NUM_WAYS (NUM_WAYS)
    ) u_update (
        .cur_bits (cur_bits),
        .way      (acc_way),
        .new_bits (next_bits)
    );

    plru_victim_pick #(
        .NUM_WAYS (NUM_WAYS)
    ) u_pick (
        .tree_bits (cur_bits),
        .locked    (eff_lock),
        .victim    (victim_way),
        .none_free (no_victim)
    );

    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !no_victim |-> !lock_mask[victim_way] && !lock_all) // R4
        else $error("locked way chosen as victim");

    AST_NONE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        no_victim == (lock_all || (&lock_mask))) // R6
        else $error("no_victim disagrees with lock state");

    AST_LOCK_ALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_all |-> no_victim && victim_way == '0) // R7
        else $error("whole-cache lock did not stop allocation");

    AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (lock_all || lock_mask != '0 || victim_way == '0)) // R9
        else $error("tree not cleared by invalidate");

    AST_AWAY_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !inval_all) |=>
            (acc_set != $past(acc_set)
             || $countones(lock_all ? {NUM_WAYS{1'b0}} : ~lock_mask) < 2
             || victim_way != $past(acc_way))) // R10
        else $error("victim equals way just accessed");

endmodule

// File: tb/sim_plru_way_sel.sv
module sim_plru_way_sel;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 8;
    localparam int SETS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inval_all = 1'b0;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_set = '0;
    logic [2:0] acc_way = '0;
    logic [7:0] lock_mask = '0;
    logic       lock_all = 1'b0;
    logic [2:0] victim_way;
    logic       no_victim;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [6:0]  mdl [SETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    plru_way_sel #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) u0 (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .acc_valid(acc_valid),
        .acc_set(acc_set), .acc_way(acc_way), .lock_mask(lock_mask),
        .lock_all(lock_all), .victim_way(victim_way), .no_victim(no_victim)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Model path update: walk from the root, marking each node away from w.
    function automatic void mdl_touch(input int s, input int w);
        int n;
        int d;
        n = 1;
        for (int b = 2; b >= 0; b--) begin
            d = (w >> b) & 1;
            mdl[s][n-1] = (d == 0);
            n = 2*n + d;
        end
    endfunction

    // Model victim: range descent with explicit scans for free ways.
    function automatic int mdl_victim(input int s, input logic [7:0] lk, output bit none);
        int lo, size, n, half;
        bit lf, rf, up;
        none = (lk == 8'hFF);
        if (none) return 0;
        lo = 0; size = 8; n = 1;
        while (size > 1) begin
            half = size / 2;
            lf = 0; rf = 0;
            for (int i = 0; i < half; i++) begin
                if (!lk[lo+i]) lf = 1;
                if (!lk[lo+half+i]) rf = 1;
            end
            up = mdl[s][n-1];
            if (up && !rf) up = 0;
            if (!up && !lf) up = 1;
            if (up) lo = lo + half;
            n = 2*n + int'(up);
            size = half;
        end
        return lo;
    endfunction

    task automatic check_pick(input string req, input int s);
        int  ev;
        bit  en;
        logic [7:0] lk;
        lk = lock_all ? 8'hFF : lock_mask;
        ev = mdl_victim(s, lk, en);
        n_tests++;
        if (int'(victim_way) != ev || no_victim != en) begin
            n_fail++;
            $display("FAIL %s set=%0d lock=%b: got way=%0d none=%0b, expected way=%0d none=%0b",
                     req, s, lk, victim_way, no_victim, ev, en);
        end
    endtask

    // Present set s at the negedge and sample after settling.
    task automatic look(input string req, input int s);
        @(negedge clk);
        acc_set = 2'(s);
        #1 check_pick(req, s);
    endtask

    // One access: check the victim before it, then clock the update.
    task automatic touch(input string req, input int s, input int w);
        @(negedge clk);
        acc_set = 2'(s); acc_way = 3'(w); acc_valid = 1'b1;
        #1 check_pick(req, s);
        @(posedge clk);
        mdl_touch(s, w);
        #1 acc_valid = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, way 0 in every set
        for (int s = 0; s < SETS; s++) look("R1", s);

        // R2 / R3: random access streams, victim checked before each access
        for (int k = 0; k < 400; k++) begin
            lfsr = lfsr_next(lfsr);
            touch((k % 2) ? "R2" : "R3", int'(lfsr[1:0]), int'(lfsr[6:4]));
        end
        for (int s = 0; s < SETS; s++) look("R3", s);

        // R4 / R5 / R6: every lock mask over several tree states
        for (int t = 0; t < 3; t++) begin
            for (int j = 0; j < 5; j++) begin
                lfsr = lfsr_next(lfsr);
                touch("R3", t, int'(lfsr[2:0]));
            end
            for (int m = 0; m < 256; m++) begin
                @(negedge clk);
                lock_mask = 8'(m); acc_set = 2'(t);
                #1 check_pick((m == 255) ? "R6" : ((m[0] ^ m[3]) ? "R5" : "R4"), t);
            end
        end
        lock_mask = '0;

        // R5: lower half locked, tree pointing to way 0 forces upper half
        @(negedge clk) inval_all = 1'b1;
        @(posedge clk); for (int s = 0; s < SETS; s++) mdl[s] = '0;
        #1 inval_all = 1'b0;
        @(negedge clk) lock_mask = 8'h0F; acc_set = 2'd1;
        #1 check_pick("R5", 1);
        n_tests++;
        if (victim_way != 3'd4) begin
            n_fail++; $display("FAIL R5: got way=%0d expected 4", victim_way);
        end

        // R7: whole-cache lock with empty mask
        @(negedge clk) lock_mask = '0; lock_all = 1'b1;
        #1 n_tests++;
        if (!no_victim || victim_way != 3'd0) begin
            n_fail++; $display("FAIL R7: got none=%0b way=%0d expected none=1 way=0", no_victim, victim_way);
        end

        // R8: accesses under lock_all and to locked ways still update
        touch("R7", 2, 0);
        touch("R7", 2, 5);
        lock_all = 1'b0;
        lock_mask = 8'h41;
        touch("R8", 2, 6);
        touch("R8", 2, 0);
        lock_mask = '0;
        look("R8", 2);

        // R10: victim moves away from the last accessed way
        for (int w = 0; w < WAYS; w++) begin
            touch("R10", 3, w);
            @(negedge clk) acc_set = 2'd3;
            #1 n_tests++;
            if (int'(victim_way) == w) begin
                n_fail++; $display("FAIL R10: got way=%0d expected not %0d", victim_way, w);
            end
        end

        // R9: invalidate together with an access clears all sets
        @(negedge clk);
        inval_all = 1'b1; acc_valid = 1'b1; acc_set = 2'd3; acc_way = 3'd0;
        @(posedge clk);
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        #1 inval_all = 1'b0; acc_valid = 1'b0;
        for (int s = 0; s < SETS; s++) look("R9", s);

        // R1: reset mid-run clears state again
        touch("R3", 0, 0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); for (int s = 0; s < SETS; s++) mdl[s] = '0;
        #1 rst_n = 1'b1;
        look("R1", 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule